// File: doc/BRIEF.md
# Control Pin I/O with Status-Change Interrupt

This block owns two general-purpose control pins. A host reaches it through a small synchronous register port with a write strobe, a read strobe, a two-bit address and a data byte. Through that port the host picks the static level each pin drives, or releases both pins to high impedance and reads their levels back as inputs. Pin levels pass through a two-stage synchronizer before they reach the read-only status word.

Pin 1 has a second role. With the interrupt option on, it stops acting as a general pin and is driven with an active-high interrupt request. The request rises when any bit of the readable status word changes. It stays high until the host reads the status word, so the host does not have to poll. The pad's electrical behaviour and the serial bus that would carry the register accesses belong to the surrounding design.

Top module: `ctrl_io_irq`

## Requirements
- R1: After a synchronous active-low reset every register bit is zero. Both pins drive low with output enable high, interrupt mode is off, no request is pending, and reads of addresses 0, 1 and 2 return zero while the pins are low.
- R2: A write to address 0 stores `wdata[1:0]`. Bit n is the level pin n drives from the next clock on, unless released or overridden. A read of address 0 returns the stored bits with the upper bits zero.
- R3: Mode bit 0 (address 1) set to 1 drives `pin_oe` low on both pins from the next clock. Pin 1 is the exception while interrupt mode is on.
- R4: A read of address 2 returns the pin levels in bits [1:0] (bit n = pin n), with upper bits zero. A level change on `pin_in` shows in the status word after exactly two rising clock edges.
- R5: Writes to address 2 or 3 change no register. A read of address 3 returns zero.
- R6: Mode bit 1 (address 1) set to 1 selects interrupt mode. Pin 1 then has `pin_oe[1]` high whatever mode bit 0 holds, and `pin_out[1]` shows the pending request instead of control bit 1.
- R7: In interrupt mode, a change of the status word sets the pending request on the next rising edge. That is the third edge after the pin change. The request stays set until a cycle with `rd_en` high and address 2 clears it at that edge. If a new change is seen in the same cycle as the read, the request stays set.
- R8: In interrupt mode, status bit 1 reads 0, so the request line cannot trigger itself. Changes are only collected while interrupt mode is on, and turning the mode off clears any pending request.
- R9: A write to address 1 stores `wdata[1:0]` as the mode (bit 0 release, bit 1 interrupt mode). A read of address 1 returns them with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 2 acknowledges the request) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pin_in | input | 2 | Levels seen on the two pads |
| pin_out | output | 2 | Levels driven onto the two pads |
| pin_oe | output | 2 | Output enables of the two pads, high = drive |

## Verification
The bench targets several corner cases:
- **Read and change in the same cycle.** A design that gives the read priority would drop that event, and the request would stay low afterwards.
- **Interrupt mode entered with pin 1 high.** Masking bit 1 is itself a status change. A design that ignores this would miss the first request.
- **Pin 1 toggling while it carries the request.** A design that leaves bit 1 unmasked would fire on its own line.
- **Release bit with interrupt mode on.** A design that applies the release to pin 1 would float the request line.
- **Writes to the status address.** A design that decodes these would corrupt the control or mode register.
- **Synchronizer latency, counted edge by edge.** A stage missing or added shifts when status and request appear.

// File: rtl/ctrl_io_pkg.sv
// Package: shared register addresses and mode-bit positions for the
// control pin I/O block. Assumes a two-bit register address space.
package ctrl_io_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_LEVEL = 2'd0,
        REG_MODE  = 2'd1,
        REG_STAT  = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    localparam int MODE_W       = 2;
    localparam int MODE_HIZ_BIT = 0;
    localparam int MODE_IRQ_BIT = 1;
    localparam int SYNC_STAGES  = 2;
endpackage

// File: rtl/io_sync.sv
// Module: io_sync
// Per-bit multi-flop synchronizer for asynchronous pad levels.
// Assumes STAGES >= 2 and that the bits are independent of one another.
module io_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0] chain [W];

    for (genvar g = 0; g < W; g++) begin : g_bit
        // Shift the pad level through the synchronizing flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= {chain[g][STAGES-2:0], d[g]};
        end
        assign q[g] = chain[g][STAGES-1];
    end
endmodule

// File: rtl/io_regs.sv
// Module: io_regs
// Holds the pin-level and mode registers and muxes read data.
// Assumes single-cycle strobes; the status address is read-only and
// address 3 is unused.
module io_regs
    import ctrl_io_pkg::*;
#(
    parameter int NPIN = 2,
    parameter int DW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [NPIN-1:0]   stat_word,
    output logic [NPIN-1:0]   ctrl_q,
    output logic [MODE_W-1:0] mode_q,
    output logic [DW-1:0]     rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    // Capture host writes to the level register.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ctrl_q <= '0;
        else if (wr_en && sel == REG_LEVEL) ctrl_q <= wdata[NPIN-1:0];
    end

    // Capture host writes to the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mode_q <= '0;
        else if (wr_en && sel == REG_MODE) mode_q <= wdata[MODE_W-1:0];
    end

    // Select the read word for the current address, zero-extended.
    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_LEVEL: rdata[NPIN-1:0]   = ctrl_q;
            REG_MODE:  rdata[MODE_W-1:0] = mode_q;
            REG_STAT:  rdata[NPIN-1:0]   = stat_word;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/io_chg_irq.sv
// Module: io_chg_irq
// Detects any change of the status word and keeps a pending request
// until the status word is read. Assumes irq_en is a registered mode bit;
// a change seen in the acknowledge cycle wins over the clear.
module io_chg_irq #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         irq_en,
    input  logic [W-1:0] stat_word,
    input  logic         ack,
    output logic         pend
);
    logic [W-1:0] prev_q;
    logic         changed;

    assign changed = (stat_word != prev_q);

    // Remember the status word seen on the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stat_word;
    end

    // Set on change, clear on acknowledge, drop while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (!irq_en) pend <= 1'b0;
        else if (changed) pend <= 1'b1;
        else if (ack)     pend <= 1'b0;
    end
endmodule

// File: rtl/ctrl_io_irq.sv
// Module: ctrl_io_irq (top)
// Two control pins with register access and a status-change interrupt
// on the last pin. Assumes the pad applies pin_oe/pin_out and returns
// the pad level on pin_in asynchronously.
module ctrl_io_irq
    import ctrl_io_pkg::*;
#(
    parameter int NPIN = 2,
    parameter int DW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe
);
    localparam int IRQ_PIN = NPIN - 1;

    logic [NPIN-1:0]   sync_q;
    logic [NPIN-1:0]   stat_word;
    logic [NPIN-1:0]   ctrl_q;
    logic [MODE_W-1:0] mode_q;
    logic              irq_mode;
    logic              hiz;
    logic              ack;
    logic              pend;

    assign irq_mode = mode_q[MODE_IRQ_BIT];
    assign hiz      = mode_q[MODE_HIZ_BIT];
    assign ack      = rd_en && (addr == ADDR_W'(REG_STAT));

    io_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_q)
    );

    // Build the status word; the request pin's own level is hidden in interrupt mode.
    always_comb begin
        stat_word          = sync_q;
        stat_word[IRQ_PIN] = sync_q[IRQ_PIN] & ~irq_mode;
    end

    io_regs #(.NPIN(NPIN), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .stat_word (stat_word),
        .ctrl_q    (ctrl_q),
        .mode_q    (mode_q),
        .rdata     (rdata)
    );

    io_chg_irq #(.W(NPIN)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_en    (irq_mode),
        .stat_word (stat_word),
        .ack       (ack),
        .pend      (pend)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        if (g == IRQ_PIN) begin : g_irq
            // Request pin: forced drive of the pending flag in interrupt mode.
            always_comb begin
                if (irq_mode) begin
                    pin_oe[g]  = 1'b1;
                    pin_out[g] = pend;
                end else begin
                    pin_oe[g]  = ~hiz;
                    pin_out[g] = ctrl_q[g];
                end
            end
        end else begin : g_gp
            // Plain pin: level from the control register, released on request.
            assign pin_oe[g]  = ~hiz;
            assign pin_out[g] = ctrl_q[g];
        end
    end
endmodule

// File: rtl/ctrl_io_irq_chk.sv
// Module: ctrl_io_irq_chk
// Property checker bound to ctrl_io_irq. Assumes the default register map.
module ctrl_io_irq_chk #(
    parameter int NPIN = 2,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic [1:0]      addr,
    input logic [DW-1:0]   wdata,
    input logic [NPIN-1:0] pin_in,
    input logic [NPIN-1:0] pin_out,
    input logic [NPIN-1:0] pin_oe,
    input logic [NPIN-1:0] ctrl_q,
    input logic [1:0]      mode_q,
    input logic [NPIN-1:0] sync_q
);
    assert_level_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && mode_q == 2'b00) |=> (pin_out[0] == $past(wdata[0]) && pin_oe[0]));

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1 && wdata[1:0] == 2'b01) |=> (pin_oe == '0));

    assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (sync_q == $past(pin_in, 2)));

    assert_stat_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[1]) |=> ($stable(ctrl_q) && $stable(mode_q)));

    assert_irq_pin_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[1] |-> pin_oe[NPIN-1]);

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1] && pin_out[NPIN-1] && !(rd_en && addr == 2'd2) && !(wr_en && addr == 2'd1))
        |=> pin_out[NPIN-1]);

    assert_irq_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1 && wdata[1:0] == 2'b00) |=> (pin_out[NPIN-1] == ctrl_q[NPIN-1]));
endmodule

bind ctrl_io_irq ctrl_io_irq_chk #(.NPIN(NPIN), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .ctrl_q  (ctrl_q),
    .mode_q  (mode_q),
    .sync_q  (sync_q)
);

// File: tb/test_ctrl_io_irq.sv
module test_ctrl_io_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [1:0] pin_in = 2'b00;
    logic [1:0] pin_out;
    logic [1:0] pin_oe;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit  live    = 1'b0;

    always #2 clk = ~clk;

    ctrl_io_irq i_ctrl_io_irq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Behavioural reference state.
    logic [1:0] m_ctrl, m_mode, m_s1, m_s2, m_prev;
    logic       m_pend;

    function automatic logic [1:0] m_stat();
        return {m_s2[1] & ~m_mode[1], m_s2[0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_mode = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0;
        end else begin
            logic [1:0] st;
            st = m_stat();
            if (!m_mode[1])                     m_pend = 1'b0;
            else if (st != m_prev)              m_pend = 1'b1;
            else if (rd_en && addr == 2'd2)     m_pend = 1'b0;
            m_prev = st;
            m_s2   = m_s1;
            m_s1   = pin_in;
            if (wr_en && addr == 2'd0) m_ctrl = wdata[1:0];
            if (wr_en && addr == 2'd1) m_mode = wdata[1:0];
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, shortly before the next rising edge.
    always @(negedge clk) begin
        #1;
        if (live && rst_n && !done) begin
            logic [1:0] e_oe, e_out;
            logic [7:0] e_rd;
            string ptag, rtag;
            e_oe[0] = ~m_mode[0];
            e_out[0] = m_ctrl[0];
            if (m_mode[1]) begin e_oe[1] = 1'b1; e_out[1] = m_pend; end
            else begin e_oe[1] = ~m_mode[0]; e_out[1] = m_ctrl[1]; end
            ptag = m_mode[1] ? "R6 pins" : (m_mode[0] ? "R3 pins" : "R2 pins");
            check(ptag, {6'd0, pin_oe}, {6'd0, e_oe});
            check(ptag, {6'd0, pin_out[0]}, {6'd0, e_out[0]});
            check(m_mode[1] ? "R7 request" : "R2 pin1", {7'd0, pin_out[1]}, {7'd0, e_out[1]});
            case (addr)
                2'd0: begin e_rd = {6'd0, m_ctrl}; rtag = "R2 read"; end
                2'd1: begin e_rd = {6'd0, m_mode}; rtag = "R9 read"; end
                2'd2: begin e_rd = {6'd0, m_stat()}; rtag = m_mode[1] ? "R8 status" : "R4 status"; end
                default: begin e_rd = 8'd0; rtag = "R5 read3"; end
            endcase
            check(rtag, rdata, e_rd);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        live  = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        check("R1 oe", {6'd0, pin_oe}, 8'h03);
        check("R1 out", {6'd0, pin_out}, 8'h00);
        for (int a = 0; a < 3; a++) begin
            addr = a[1:0]; #0.5;
            check("R1 read", rdata, 8'h00);
        end
        // R2 levels, R9 mode readback
        wr(2'd0, 8'hFE); step(2);
        check("R2 level", {6'd0, pin_out}, 8'h02);
        wr(2'd0, 8'h01); step(1);
        // R3 release
        wr(2'd1, 8'h01); step(1);
        check("R3 release", {6'd0, pin_oe}, 8'h00);
        // R4 status sampling, various patterns
        pin_in = 2'b01; step(1); addr = 2'd2; step(3);
        pin_in = 2'b10; step(4);
        pin_in = 2'b11; step(4);
        // R5 writes to status and address 3 ignored
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF); addr = 2'd0; step(1);
        check("R5 level kept", rdata, 8'h01);
        addr = 2'd1; #0.5;
        check("R5 mode kept", rdata, 8'h01);
        // R6/R8 enter interrupt mode with release still set; pin1 high gets masked
        wr(2'd1, 8'h03); step(3);
        check("R6 pin1 driven", {7'd0, pin_oe[1]}, 8'h01);
        check("R8 mask change fires", {7'd0, pin_out[1]}, 8'h01);
        rd(2'd2); step(1);
        check("R7 cleared", {7'd0, pin_out[1]}, 8'h00);
        // R8 pin1 toggle does not trigger
        pin_in = 2'b01; step(5);
        check("R8 no self trigger", {7'd0, pin_out[1]}, 8'h00);
        // R7 pin0 change raises on third edge, holds
        pin_in = 2'b00; step(2);
        check("R7 not yet", {7'd0, pin_out[1]}, 8'h00);
        step(1);
        check("R7 raised", {7'd0, pin_out[1]}, 8'h01);
        step(6);
        check("R7 held", {7'd0, pin_out[1]}, 8'h01);
        // R7 change in the same cycle as read keeps it set
        pin_in = 2'b01; step(1);
        @(negedge clk); rd_en = 1'b1; addr = 2'd2;
        @(negedge clk); rd_en = 1'b0;
        #0.5;
        check("R7 change beats read", {7'd0, pin_out[1]}, 8'h01);
        rd(2'd2); step(1);
        // R8 leaving interrupt mode clears
        pin_in = 2'b00; step(4);
        wr(2'd1, 8'h00); step(1);
        check("R8 mode off", {6'd0, pin_out}, 8'h01);
        // Random traffic compared against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            wr_en  = ($urandom_range(0, 5) == 0);
            rd_en  = ($urandom_range(0, 3) == 0);
            addr   = 2'($urandom_range(0, 3));
            wdata  = 8'($urandom);
            if ($urandom_range(0, 6) == 0) pin_in = 2'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        step(4);
        report();
    end
endmodule